// File: doc/BRIEF.md
# Signed/Unsigned Multiplier with Fractional Scaler

This block forms the product of two 16-bit operands. Each operand carries its own signedness flag. The datapath extends each operand into a 17th bit (sign copy or zero) and multiplies the two 17-bit values in one two's-complement partial-product array. Signed, unsigned and mixed-sign products therefore all come from the same hardware.

A scaler follows the array. In integer alignment it passes the product through unchanged. In fractional alignment it shifts the product left by one place, so that two Q15 operands give a 1.31 result. The 33-bit scaled value is sign-extended to 40 bits for an accumulator datapath.

A second port gives the integer view of the result. In word mode it carries a 32-bit product. In byte mode it carries a 16-bit product of the low operand bytes. The inputs are captured by a single output register, so every result appears one clock after its request.

Top module: `mul17_scaled`

## Requirements
- R1: With a signedness flag low in word mode, the operand is zero-extended: 0xFFFF (flag low) times 0x0002 (flag low) gives acc_result 0x000001FFFE and int_result 0x0001FFFE.
- R2: With a signedness flag high in word mode, bit 15 is copied into bit 16: 0xFFFF (flag high) times 0x0002 (flag low) gives acc_result 0xFFFFFFFFFE and int_result 0xFFFFFFFE.
- R3: Mixed-sign products are exact: 0xFFFF (a signed) times 0xFFFF (b unsigned) gives -65535, which is acc_result 0xFFFFFF0001 and int_result 0xFFFF0001.
- R4: With frac_mode low, acc_result is the exact product sign-extended to 40 bits. In word mode, int_result equals the low 32 bits of that product.
- R5: With frac_mode high, the product is shifted left by one bit and truncated to 33 bits before sign extension: signed 0x4000 times signed 0x4000 gives 0x0020000000.
- R6: In fractional mode, signed 0x8000 times signed 0x8000 gives int_result 0x80000000 and acc_result 0x0080000000 (positive, +1.0 in Q31).
- R7: acc_result bits 39 to 33 always equal bit 32.
- R8: With byte_mode high, only bits 7:0 of each operand are used, each extended from bit 7 according to its own flag. int_result[15:0] holds the (scaled) product, int_result[31:16] is zero, and acc_result holds the same product sign-extended. Bits 15:8 of the operands have no effect.
- R9: Results and out_valid appear on the first rising edge after in_valid is sampled high. When in_valid is low, out_valid drops and both result ports hold their previous values.
- R10: A synchronous active-low reset clears out_valid, acc_result and int_result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe; operands and controls are sampled when high |
| opa | input | 16 | First operand |
| opb | input | 16 | Second operand |
| a_signed | input | 1 | 1: opa is two's complement; 0: unsigned |
| b_signed | input | 1 | 1: opb is two's complement; 0: unsigned |
| frac_mode | input | 1 | 1: fractional alignment (shift left one); 0: integer |
| byte_mode | input | 1 | 1: use the low byte of each operand, 16-bit integer result |
| out_valid | output | 1 | High for the cycle after an accepted request |
| acc_result | output | 40 | Scaled product sign-extended to 40 bits |
| int_result | output | 32 | 32-bit product (word) or zero-padded 16-bit product (byte) |

## Verification
Every result is due exactly one rising edge after its request is sampled. The operand path is purely combinational up to the single output register. The bench drives a request at a falling edge and compares all three outputs at the next falling edge, half a period after the capturing edge. It then applies the next request at that same falling edge, so its behavioural model always predicts the register contents one edge ahead. Idle cycles are compared in the same way, which confirms that the outputs hold their values and that out_valid drops.

// File: rtl/mul17_pkg.sv
// Package: shared widths and the request-mode record for the scaled multiplier.
// Assumes 16-bit operands; the derived widths follow from that choice.
package mul17_pkg;
    localparam int OP_W   = 16;
    localparam int BYTE_W = 8;
    localparam int ACC_W  = 40;

    // Per-request control flags, captured alongside the operands.
    typedef struct packed {
        logic a_signed;
        logic b_signed;
        logic frac;
        logic byte_sel;
    } mul_mode_t;
endpackage

// File: rtl/mul17_opnd_ext.sv
// Operand extender: widens a 16-bit operand into one extra bit.
// In word mode the full operand is used, and bit OP_W is either a copy of
// the top bit (signed) or zero (unsigned). In byte mode only the low
// BYTE_W bits are used, extended the same way from bit BYTE_W-1.
// Assumes BYTE_W < OP_W.
module mul17_opnd_ext #(
    parameter int OP_W   = 16,
    parameter int BYTE_W = 8
) (
    input  logic [OP_W-1:0] x,
    input  logic            is_signed,
    input  logic            byte_sel,
    output logic [OP_W:0]   ext
);
    localparam int PAD_BYTE = OP_W + 1 - BYTE_W;

    logic fill_word;
    logic fill_byte;

    // Pick the fill bit for each width: sign copy or zero.
    always_comb begin
        fill_word = is_signed & x[OP_W-1];
        fill_byte = is_signed & x[BYTE_W-1];
    end

    // Select the word or byte view of the operand.
    always_comb begin
        if (byte_sel) begin
            ext = {{PAD_BYTE{fill_byte}}, x[BYTE_W-1:0]};
        end else begin
            ext = {fill_word, x};
        end
    end
endmodule

// File: rtl/mul17_pp_array.sv
// Two's-complement partial-product array for two EXT_W-bit signed operands.
// Row i adds the multiplicand shifted by i when multiplier bit i is set.
// The top row has negative weight and is subtracted. The sum is kept to
// P_W = 2*EXT_W-1 bits: with operands that come from OP_W = EXT_W-1 bits,
// the true product always fits that width, so modular sums are exact.
module mul17_pp_array #(
    parameter int EXT_W = 17
) (
    input  logic [EXT_W-1:0]   a,
    input  logic [EXT_W-1:0]   b,
    output logic [2*EXT_W-2:0] prod
);
    localparam int P_W = 2 * EXT_W - 1;

    logic [P_W-1:0] a_sx;
    logic [P_W-1:0] row [EXT_W];

    // Sign-extend the multiplicand to the product width.
    always_comb begin
        a_sx = {{(P_W - EXT_W){a[EXT_W-1]}}, a};
    end

    // One gated, shifted copy of the multiplicand per multiplier bit.
    for (genvar i = 0; i < EXT_W; i++) begin : g_row
        always_comb begin
            row[i] = b[i] ? (a_sx << i) : '0;
        end
    end

    // Sum positive-weight rows and subtract the sign-weighted top row.
    always_comb begin
        logic [P_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < EXT_W - 1; i++) begin
            acc = acc + row[i];
        end
        prod = acc - row[EXT_W-1];
    end
endmodule

// File: rtl/mul17_scaler.sv
// Scaler: selects integer or fractional (shift left one) alignment of the
// SC_W-bit product, then sign-extends the result to ACC_W bits.
// In fractional mode the bit shifted out of the top is dropped.
// Assumes ACC_W > SC_W.
module mul17_scaler #(
    parameter int SC_W  = 33,
    parameter int ACC_W = 40
) (
    input  logic [SC_W-1:0]  prod,
    input  logic             frac,
    output logic [SC_W-1:0]  scaled,
    output logic [ACC_W-1:0] acc
);
    localparam int PAD = ACC_W - SC_W;

    // Align the product for Q31 or integer use.
    always_comb begin
        scaled = frac ? {prod[SC_W-2:0], 1'b0} : prod;
    end

    // Sign-extend the aligned value for the accumulator path.
    always_comb begin
        acc = {{PAD{scaled[SC_W-1]}}, scaled};
    end
endmodule

// File: rtl/mul17_scaled.sv
// Top: signed/unsigned/mixed 17x17 multiplier with fractional scaler and a
// single output register. Operands and flags sampled with in_valid appear
// on the outputs one edge later; without in_valid the results hold.
// Synchronous active-low reset clears every output.
module mul17_scaled
    import mul17_pkg::*;
#(
    parameter int OPW   = OP_W,
    parameter int BW    = BYTE_W,
    parameter int AW    = ACC_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [OPW-1:0] opa,
    input  logic [OPW-1:0] opb,
    input  logic          a_signed,
    input  logic          b_signed,
    input  logic          frac_mode,
    input  logic          byte_mode,
    output logic          out_valid,
    output logic [AW-1:0] acc_result,
    output logic [2*OPW-1:0] int_result
);
    localparam int EXT_W = OPW + 1;
    localparam int SC_W  = 2 * EXT_W - 1;
    localparam int INT_W = 2 * OPW;
    localparam int BP_W  = 2 * BW;

    mul_mode_t      mode;
    logic [EXT_W-1:0] a_ext;
    logic [EXT_W-1:0] b_ext;
    logic [SC_W-1:0]  prod;
    logic [SC_W-1:0]  scaled;
    logic [AW-1:0]    acc_nxt;
    logic [INT_W-1:0] int_nxt;

    // Gather the request flags into one record.
    always_comb begin
        mode = '{a_signed: a_signed, b_signed: b_signed,
                 frac: frac_mode, byte_sel: byte_mode};
    end

    mul17_opnd_ext #(.OP_W(OPW), .BYTE_W(BW)) u_ext_a (
        .x(opa), .is_signed(mode.a_signed), .byte_sel(mode.byte_sel), .ext(a_ext)
    );

    mul17_opnd_ext #(.OP_W(OPW), .BYTE_W(BW)) u_ext_b (
        .x(opb), .is_signed(mode.b_signed), .byte_sel(mode.byte_sel), .ext(b_ext)
    );

    mul17_pp_array #(.EXT_W(EXT_W)) u_array (
        .a(a_ext), .b(b_ext), .prod(prod)
    );

    mul17_scaler #(.SC_W(SC_W), .ACC_W(AW)) u_scaler (
        .prod(prod), .frac(mode.frac), .scaled(scaled), .acc(acc_nxt)
    );

    // Form the integer view: full word, or zero-padded byte product.
    always_comb begin
        if (mode.byte_sel) begin
            int_nxt = {{(INT_W - BP_W){1'b0}}, scaled[BP_W-1:0]};
        end else begin
            int_nxt = scaled[INT_W-1:0];
        end
    end

    // Output register: capture on request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            acc_result <= '0;
            int_result <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                acc_result <= acc_nxt;
                int_result <= int_nxt;
            end
        end
    end

    AST_VALID_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R9
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(acc_result) && $stable(int_result))); // R9
    AST_ACC_TOP_REPLICATED: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(acc_result[AW-1:SC_W-1]) == 0) ||
        ($countones(acc_result[AW-1:SC_W-1]) == AW - SC_W + 1)); // R7
    AST_UNSIGNED_NOT_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !a_signed && !b_signed && !frac_mode) |=> !acc_result[AW-1]); // R1
    AST_WORD_INT_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !byte_mode) |=> (int_result == acc_result[INT_W-1:0])); // R4
    AST_BYTE_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && byte_mode) |=> (int_result[INT_W-1:BP_W] == '0)); // R8
    AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !byte_mode && opa == '0) |=> (acc_result == '0)); // R4
endmodule

// File: tb/mul17_scaled_bench.sv
module mul17_scaled_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic        a_signed = 1'b0;
    logic        b_signed = 1'b0;
    logic        frac_mode = 1'b0;
    logic        byte_mode = 1'b0;
    logic        out_valid;
    logic [39:0] acc_result;
    logic [31:0] int_result;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Expected register contents after the next edge, plus its tag.
    logic        exp_valid = 1'b0;
    logic [39:0] exp_acc = '0;
    logic [31:0] exp_int = '0;
    string       exp_tag = "R10";
    logic [31:0] rng = 32'h1234_5678;

    mul17_scaled u_mul17_scaled (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
        .a_signed(a_signed), .b_signed(b_signed), .frac_mode(frac_mode),
        .byte_mode(byte_mode), .out_valid(out_valid), .acc_result(acc_result),
        .int_result(int_result)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Behavioural product from the requirement text.
    function automatic void ref_calc(input logic [15:0] a, input logic [15:0] b,
                                     input bit as, input bit bs, input bit fr, input bit by,
                                     output logic [39:0] acc, output logic [31:0] ires);
        longint ea, eb, p, m;
        if (by) begin
            ea = as ? longint'($signed(a[7:0])) : longint'(a[7:0]);
            eb = bs ? longint'($signed(b[7:0])) : longint'(b[7:0]);
        end else begin
            ea = as ? longint'($signed(a)) : longint'(a);
            eb = bs ? longint'($signed(b)) : longint'(b);
        end
        p = ea * eb;
        if (fr) p = p * 2;
        m = p & 64'h1_FFFF_FFFF;
        if (m >= 64'sh1_0000_0000) m = m - 64'sh2_0000_0000;
        acc  = m[39:0];
        ires = by ? {16'h0000, m[15:0]} : m[31:0];
    endfunction

    task automatic cmp(input string tag, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // Compare the outputs due now, then apply the next request.
    task automatic step(input string tag, input bit v, input logic [15:0] a,
                        input logic [15:0] b, input bit as, input bit bs,
                        input bit fr, input bit by);
        logic [39:0] nacc;
        logic [31:0] nint;
        @(negedge clk);
        cmp(exp_tag, "out_valid", 64'(out_valid), 64'(exp_valid));
        cmp(exp_tag, "acc_result", 64'(acc_result), 64'(exp_acc));
        cmp(exp_tag, "int_result", 64'(int_result), 64'(exp_int));
        cmp("R7", "acc_result[39:33]", 64'(acc_result[39:33]), 64'({7{acc_result[32]}}));
        in_valid = v; opa = a; opb = b;
        a_signed = as; b_signed = bs; frac_mode = fr; byte_mode = by;
        exp_valid = v;
        exp_tag = tag;
        if (v) begin
            ref_calc(a, b, as, bs, fr, by, nacc, nint);
            exp_acc = nacc;
            exp_int = nint;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state observed while reset is held
        cmp("R10", "out_valid", 64'(out_valid), 64'd0);
        cmp("R10", "acc_result", 64'(acc_result), 64'd0);
        cmp("R10", "int_result", 64'(int_result), 64'd0);
        rst_n = 1'b1;
        step("R1", 1, 16'hFFFF, 16'h0002, 0, 0, 0, 0);
        step("R2", 1, 16'hFFFF, 16'h0002, 1, 0, 0, 0);
        step("R3", 1, 16'hFFFF, 16'hFFFF, 1, 0, 0, 0);
        step("R3", 1, 16'h8000, 16'h8000, 0, 1, 0, 0);
        step("R4", 1, 16'h7FFF, 16'h7FFF, 1, 1, 0, 0);
        step("R4", 1, 16'hFFFF, 16'hFFFF, 0, 0, 0, 0);
        step("R5", 1, 16'h4000, 16'h4000, 1, 1, 1, 0);
        step("R5", 1, 16'hC000, 16'h4000, 1, 1, 1, 0);
        step("R6", 1, 16'h8000, 16'h8000, 1, 1, 1, 0);
        step("R8", 1, 16'hAB80, 16'h12FF, 1, 1, 0, 1);
        step("R8", 1, 16'h0080, 16'h00FF, 1, 1, 0, 1);
        step("R8", 1, 16'h5580, 16'hAAFF, 0, 0, 0, 1);
        step("R8", 1, 16'h3C81, 16'hC37F, 1, 0, 1, 1);
        // R9: idle cycles with changed operands must hold the results
        step("R9", 0, 16'h1234, 16'h5678, 1, 1, 1, 0);
        step("R9", 0, 16'hFFFF, 16'hFFFF, 0, 0, 0, 1);
        step("R9", 1, 16'h0003, 16'h0005, 0, 0, 0, 0);
        for (int k = 0; k < 400; k++) begin
            logic [15:0] ra, rb;
            logic [3:0]  fl;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            ra = rng[15:0]; rb = rng[31:16];
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            fl = rng[3:0];
            step(fl[3] ? "R8" : (fl[2] ? "R5" : "R4"), rng[7:4] != 4'h0,
                 ra, rb, fl[0], fl[1], fl[2], fl[3]);
        end
        step("R9", 0, 16'h0000, 16'h0000, 0, 0, 0, 0);
        step("R9", 0, 16'h0000, 16'h0000, 0, 0, 0, 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule